// File: doc/BRIEF.md
# AHB Subordinate Burst Beat Tracker

This block sits on the subordinate side of an AHB bus. It watches the address-phase controls of each transfer and turns every accepted beat of a burst into a one-cycle strobe carrying the beat's address and its position in the burst. It also flags where a burst opens and where it closes, so a local memory or FIFO can frame the data. It never relies on the declared length of a fixed-length burst: a burst closes on whatever beats actually arrive, a pause cycle keeps the burst alive, and an idle cycle ends it.

The controller has three states. `ST_IDLE` means that no burst is open. `ST_ACTIVE` means that a burst is open and its last accepted cycle was a beat. `ST_PAUSED` means that a burst is open and its last accepted cycle was a pause. There are eight transitions:

- **open**: `ST_IDLE` to `ST_ACTIVE` on a NONSEQ.
- **single**: a NONSEQ of a one-beat burst, which stays in `ST_IDLE`.
- **orphan**: a SEQ in `ST_IDLE`, which reports an error and leaves the state as it is.
- **beat**: `ST_ACTIVE` or `ST_PAUSED` to `ST_ACTIVE` on a SEQ.
- **last**: back to `ST_IDLE` on the final beat of a fixed-length burst.
- **hold**: to `ST_PAUSED` on a BUSY.
- **close**: to `ST_IDLE` on an IDLE or on a deselected cycle.
- **restart**: a NONSEQ while a burst is open, which closes that burst and opens the new one in the same cycle.

Only the address of the first beat is taken from the bus. Every later address is produced by the tracker itself from the stored context.

All outputs are registered. The outputs for a cycle sampled at a rising clock edge appear just after that edge and last one cycle.

Top module: `ahb_burst_tracker`

## Requirements
- R1: After reset no burst is open and every output is low or zero. A SEQ arriving straight after reset is treated as an orphan.
- R2: The bus cycle is decoded from `xfer_kind` as follows: 0 is IDLE, 1 is BUSY, 2 is NONSEQ and 3 is SEQ. A beat is accepted only when `sel_i` is high, `bus_ready` is high and the cycle is NONSEQ or SEQ. BUSY cycles, IDLE cycles and deselected cycles never raise `beat_vld`.
- R3: A NONSEQ opens a burst. The beat is reported with `burst_start`, its address is `xfer_addr` and `beat_idx` is 0.
- R4: Each SEQ beat's address is the previous beat address plus 2^`beat_size` bytes, where `beat_size` 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. The value on `xfer_addr` during SEQ beats is ignored. `beat_idx` counts up from 0.
- R5: In wrapping bursts the address stays inside the block aligned to the beat count times 2^`beat_size` bytes. When it passes the top of that block it wraps back to the block's base.
- R6: `burst_kind` selects the burst type:
  - 0: a single beat.
  - 1: an incrementing burst of undefined length.
  - 2: wrapping, 4 beats.
  - 3: incrementing, 4 beats.
  - 4: wrapping, 8 beats.
  - 5: incrementing, 8 beats.
  - 6: wrapping, 16 beats.
  - 7: incrementing, 16 beats.

  For a fixed-length burst, `burst_end` is raised together with its final beat and the burst is closed. Any further SEQ is then an orphan.
- R7: An open burst is closed by an IDLE cycle, by a deselected cycle, or by a new NONSEQ. `burst_end` is raised in the output cycle of that closing bus cycle. When the close is caused by a NONSEQ, the same output cycle also carries the new burst's `burst_start` beat.
- R8: When a fixed-length burst is closed before its final beat, `early_term` is raised together with `burst_end`, and `early_cnt` gives the number of beats received. A burst of undefined length never raises `early_term`.
- R9: A BUSY inside an open burst is a pause. It keeps the address, the beat count and the burst type, and the next SEQ continues from them.
- R10: A SEQ with no open burst raises `proto_err` for one cycle. It produces no beat and no end, and it does not open a burst.
- R11: A cycle with `bus_ready` low is ignored completely: no output pulses and no context change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | This subordinate is selected |
| xfer_kind | input | 2 | Transfer kind (IDLE, BUSY, NONSEQ, SEQ) |
| burst_kind | input | 3 | Burst type code |
| beat_size | input | 3 | Log2 of the beat size in bytes |
| xfer_addr | input | AW | Address phase address |
| bus_ready | input | 1 | Bus ready; the address phase is sampled when high |
| beat_vld | output | 1 | An accepted beat is reported this cycle |
| beat_addr | output | AW | Address of the reported beat |
| beat_idx | output | IDXW | Position of the reported beat, starting at 0 |
| burst_start | output | 1 | The reported beat opens a burst |
| burst_end | output | 1 | A burst closed |
| early_term | output | 1 | A fixed-length burst closed before its final beat |
| early_cnt | output | 5 | Beats received by the truncated burst |
| proto_err | output | 1 | A SEQ arrived with no open burst |

## Verification
The bench drives bursts that run to full length in three forms: an incrementing word burst, wrapping bursts whose start address lies partway into the block at word, halfword and byte size, and a single-beat burst. These separate the plain step from the wrap and the length decoding. A wrong address is placed on one SEQ beat, which shows whether the tracker uses its own computed address. Truncated bursts are then closed in three ways: by an IDLE, by a new NONSEQ and by a deselected cycle. A truncated fixed-length burst is told apart from a burst of undefined length by whether `early_term` is raised. BUSY and stall cycles inside a burst confirm that they pause the burst without ending it. A SEQ after reset, after a completed burst and after an IDLE must each give only a protocol error.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int LENW = 5;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ACTIVE = 2'b01,
        ST_PAUSED = 2'b10
    } trk_state_e;

    typedef struct packed {
        logic            fixed;
        logic            wrap;
        logic [LENW-1:0] len;
    } burst_info_t;

endpackage

// File: rtl/bt_burst_decode.sv
module bt_burst_decode
    import bt_pkg::*;
(
    input  logic [2:0]  burst_code,
    output burst_info_t info
);

    always_comb begin
        info = '0;
        unique case (burst_code)
            3'd0: begin info.fixed = 1'b1; info.wrap = 1'b0; info.len = LENW'(1);  end
            3'd1: begin info.fixed = 1'b0; info.wrap = 1'b0; info.len = LENW'(0);  end
            3'd2: begin info.fixed = 1'b1; info.wrap = 1'b1; info.len = LENW'(4);  end
            3'd3: begin info.fixed = 1'b1; info.wrap = 1'b0; info.len = LENW'(4);  end
            3'd4: begin info.fixed = 1'b1; info.wrap = 1'b1; info.len = LENW'(8);  end
            3'd5: begin info.fixed = 1'b1; info.wrap = 1'b0; info.len = LENW'(8);  end
            3'd6: begin info.fixed = 1'b1; info.wrap = 1'b1; info.len = LENW'(16); end
            default: begin info.fixed = 1'b1; info.wrap = 1'b0; info.len = LENW'(16); end
        endcase
    end

endmodule

// File: rtl/bt_addr_step.sv
module bt_addr_step
    import bt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]   cur,
    input  logic [2:0]      size,
    input  logic            wrap,
    input  logic [LENW-1:0] len,
    output logic [AW-1:0]   nxt
);

    logic [AW-1:0] step;
    logic [AW-1:0] blk;
    logic [AW-1:0] mask;
    logic [AW-1:0] sum;

    always_comb begin
        step = AW'(1) << size;
        blk  = AW'(len) << size;
        mask = blk - AW'(1);
        sum  = cur + step;
        nxt  = wrap ? ((cur & ~mask) | (sum & mask)) : sum;
    end

endmodule

// File: rtl/bt_fsm.sv
module bt_fsm
    import bt_pkg::*;
#(
    parameter int AW   = 32,
    parameter int IDXW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_i,
    input  logic [1:0]      xfer_kind,
    input  logic [2:0]      beat_size,
    input  logic [AW-1:0]   xfer_addr,
    input  logic            bus_ready,
    input  burst_info_t     new_info,
    input  logic [AW-1:0]   step_addr,
    output logic [AW-1:0]   ctx_addr,
    output logic [2:0]      ctx_size,
    output logic            ctx_wrap,
    output logic [LENW-1:0] ctx_len,
    output logic            beat_vld,
    output logic [AW-1:0]   beat_addr,
    output logic [IDXW-1:0] beat_idx,
    output logic            burst_start,
    output logic            burst_end,
    output logic            early_term,
    output logic [LENW-1:0] early_cnt,
    output logic            proto_err
);

    trk_state_e      state, nx_state;
    trans_e          tr;
    logic            cyc_ns, cyc_sq, cyc_bz, cyc_cl;

    logic [AW-1:0]   addr_q, nx_addr;
    logic [2:0]      size_q, nx_size;
    logic            wrap_q, nx_wrap;
    logic            fixed_q, nx_fixed;
    logic [LENW-1:0] len_q, nx_len;
    logic [IDXW-1:0] cnt_q, nx_cnt;

    logic            o_vld, o_start, o_end, o_eterm, o_perr;
    logic [AW-1:0]   o_addr;
    logic [IDXW-1:0] o_idx;
    logic [LENW-1:0] o_ecnt;

    assign tr     = trans_e'(xfer_kind);
    assign cyc_ns = bus_ready && sel_i && (tr == TR_NSEQ);
    assign cyc_sq = bus_ready && sel_i && (tr == TR_SEQ);
    assign cyc_bz = bus_ready && sel_i && (tr == TR_BUSY);
    assign cyc_cl = bus_ready && (!sel_i || (tr == TR_IDLE));

    assign ctx_addr = addr_q;
    assign ctx_size = size_q;
    assign ctx_wrap = wrap_q;
    assign ctx_len  = len_q;

    always_comb begin
        nx_state = state;
        nx_addr  = addr_q;
        nx_size  = size_q;
        nx_wrap  = wrap_q;
        nx_fixed = fixed_q;
        nx_len   = len_q;
        nx_cnt   = cnt_q;
        o_vld    = 1'b0;
        o_addr   = '0;
        o_idx    = '0;
        o_start  = 1'b0;
        o_end    = 1'b0;
        o_eterm  = 1'b0;
        o_ecnt   = '0;
        o_perr   = 1'b0;

        unique case (state)
            ST_IDLE: begin
                if (cyc_sq) begin
                    o_perr = 1'b1;
                end
            end
            ST_ACTIVE, ST_PAUSED: begin
                if (cyc_cl || cyc_ns) begin
                    o_end    = 1'b1;
                    o_eterm  = fixed_q;
                    o_ecnt   = fixed_q ? cnt_q[LENW-1:0] : '0;
                    nx_state = ST_IDLE;
                end else if (cyc_bz) begin
                    nx_state = ST_PAUSED;
                end else if (cyc_sq) begin
                    o_vld    = 1'b1;
                    o_addr   = step_addr;
                    o_idx    = cnt_q;
                    nx_addr  = step_addr;
                    nx_cnt   = cnt_q + IDXW'(1);
                    nx_state = ST_ACTIVE;
                    if (fixed_q && (nx_cnt == IDXW'(len_q))) begin
                        o_end    = 1'b1;
                        nx_state = ST_IDLE;
                    end
                end
            end
            default: nx_state = ST_IDLE;
        endcase

        if (cyc_ns) begin
            o_vld    = 1'b1;
            o_addr   = xfer_addr;
            o_idx    = '0;
            o_start  = 1'b1;
            nx_addr  = xfer_addr;
            nx_size  = beat_size;
            nx_wrap  = new_info.wrap;
            nx_fixed = new_info.fixed;
            nx_len   = new_info.len;
            nx_cnt   = IDXW'(1);
            nx_state = ST_ACTIVE;
            if (new_info.fixed && (new_info.len == LENW'(1))) begin
                o_end    = 1'b1;
                nx_state = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            size_q  <= '0;
            wrap_q  <= 1'b0;
            fixed_q <= 1'b0;
            len_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state   <= nx_state;
            addr_q  <= nx_addr;
            size_q  <= nx_size;
            wrap_q  <= nx_wrap;
            fixed_q <= nx_fixed;
            len_q   <= nx_len;
            cnt_q   <= nx_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_vld    <= 1'b0;
            beat_addr   <= '0;
            beat_idx    <= '0;
            burst_start <= 1'b0;
            burst_end   <= 1'b0;
            early_term  <= 1'b0;
            early_cnt   <= '0;
            proto_err   <= 1'b0;
        end else begin
            beat_vld    <= o_vld;
            beat_addr   <= o_addr;
            beat_idx    <= o_idx;
            burst_start <= o_start;
            burst_end   <= o_end;
            early_term  <= o_eterm;
            early_cnt   <= o_ecnt;
            proto_err   <= o_perr;
        end
    end

    AST_START_IS_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> (beat_vld && beat_idx == '0)); // R3
    AST_ETERM_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
        early_term |-> burst_end); // R8
    AST_ORPHAN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (!beat_vld && !burst_end)); // R10
    AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> (!beat_vld && !burst_end && !proto_err)); // R11
    AST_BUSY_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_bz |=> (!beat_vld && !burst_end)); // R2
    AST_BUSY_KEEPS_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_bz && state != ST_IDLE) |=> ($stable(addr_q) && $stable(cnt_q) && state == ST_PAUSED)); // R9
    AST_FIXED_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && fixed_q) |-> (cnt_q < IDXW'(len_q))); // R6

endmodule

// File: rtl/ahb_burst_tracker.sv
module ahb_burst_tracker
    import bt_pkg::*;
#(
    parameter int AW   = 32,
    parameter int IDXW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_i,
    input  logic [1:0]      xfer_kind,
    input  logic [2:0]      burst_kind,
    input  logic [2:0]      beat_size,
    input  logic [AW-1:0]   xfer_addr,
    input  logic            bus_ready,
    output logic            beat_vld,
    output logic [AW-1:0]   beat_addr,
    output logic [IDXW-1:0] beat_idx,
    output logic            burst_start,
    output logic            burst_end,
    output logic            early_term,
    output logic [4:0]      early_cnt,
    output logic            proto_err
);

    burst_info_t     new_info;
    logic [AW-1:0]   ctx_addr;
    logic [AW-1:0]   step_addr;
    logic [2:0]      ctx_size;
    logic            ctx_wrap;
    logic [LENW-1:0] ctx_len;

    bt_burst_decode u_decode (
        .burst_code (burst_kind),
        .info       (new_info)
    );

    bt_addr_step #(.AW(AW)) u_step (
        .cur  (ctx_addr),
        .size (ctx_size),
        .wrap (ctx_wrap),
        .len  (ctx_len),
        .nxt  (step_addr)
    );

    bt_fsm #(.AW(AW), .IDXW(IDXW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel_i),
        .xfer_kind   (xfer_kind),
        .beat_size   (beat_size),
        .xfer_addr   (xfer_addr),
        .bus_ready   (bus_ready),
        .new_info    (new_info),
        .step_addr   (step_addr),
        .ctx_addr    (ctx_addr),
        .ctx_size    (ctx_size),
        .ctx_wrap    (ctx_wrap),
        .ctx_len     (ctx_len),
        .beat_vld    (beat_vld),
        .beat_addr   (beat_addr),
        .beat_idx    (beat_idx),
        .burst_start (burst_start),
        .burst_end   (burst_end),
        .early_term  (early_term),
        .early_cnt   (early_cnt),
        .proto_err   (proto_err)
    );

    AST_START_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> !burst_start); // R2

endmodule

// File: tb/ahb_burst_tracker_tb.sv
module ahb_burst_tracker_tb;

    localparam logic [1:0] K_IDLE = 2'd0, K_BUSY = 2'd1, K_NSEQ = 2'd2, K_SEQ = 2'd3;
    localparam logic [2:0] B_SINGLE = 3'd0, B_INCR = 3'd1, B_WRAP4 = 3'd2, B_INCR4 = 3'd3;
    localparam logic [2:0] B_WRAP8 = 3'd4, B_INCR8 = 3'd5, B_WRAP16 = 3'd6;

    typedef struct packed {
        logic        v;
        logic [31:0] a;
        logic [9:0]  i;
        logic        s;
        logic        e;
        logic        t;
        logic [4:0]  c;
        logic        p;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b0;
    logic [1:0]  xfer_kind = K_IDLE;
    logic [2:0]  burst_kind = '0;
    logic [2:0]  beat_size = '0;
    logic [31:0] xfer_addr = '0;
    logic        bus_ready = 1'b1;
    logic        beat_vld, burst_start, burst_end, early_term, proto_err;
    logic [31:0] beat_addr;
    logic [9:0]  beat_idx;
    logic [4:0]  early_cnt;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    ev_t   exp_q[$];
    string tag_q[$];

    bit          m_open = 0;
    bit          m_fixed = 0;
    bit          m_wrap = 0;
    int unsigned m_len = 0;
    int unsigned m_size = 0;
    int unsigned m_cnt = 0;
    int unsigned m_addr = 0;

    always #4 clk = ~clk;

    ahb_burst_tracker #(.AW(32), .IDXW(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .xfer_kind(xfer_kind),
        .burst_kind(burst_kind), .beat_size(beat_size), .xfer_addr(xfer_addr),
        .bus_ready(bus_ready), .beat_vld(beat_vld), .beat_addr(beat_addr),
        .beat_idx(beat_idx), .burst_start(burst_start), .burst_end(burst_end),
        .early_term(early_term), .early_cnt(early_cnt), .proto_err(proto_err)
    );

    task automatic cyc(input logic s, input logic [1:0] k, input logic [2:0] b,
                       input logic [2:0] z, input logic [31:0] a, input logic r,
                       input string tag);
        ev_t ev;
        int unsigned step, blk, base;
        @(negedge clk);
        sel_i = s; xfer_kind = k; burst_kind = b; beat_size = z; xfer_addr = a; bus_ready = r;
        ev = '0;
        if (r) begin
            if (m_open && (!s || k == K_IDLE || k == K_NSEQ)) begin
                ev.e = 1'b1;
                if (m_fixed) begin ev.t = 1'b1; ev.c = 5'(m_cnt); end
                m_open = 0;
            end
            if (s && k == K_NSEQ) begin
                m_fixed = (b != B_INCR);
                m_wrap  = (b == 3'd2 || b == 3'd4 || b == 3'd6);
                m_len   = (b == 3'd0) ? 1 : (b == 3'd1) ? 0 : (b <= 3'd3) ? 4 : (b <= 3'd5) ? 8 : 16;
                m_size = z; m_addr = a; m_cnt = 1; m_open = 1;
                ev.v = 1'b1; ev.a = a; ev.i = '0; ev.s = 1'b1;
                if (m_fixed && m_len == 1) begin ev.e = 1'b1; m_open = 0; end
            end else if (s && k == K_SEQ) begin
                if (!m_open) ev.p = 1'b1;
                else begin
                    step = 1 << m_size;
                    if (m_wrap) begin
                        blk = m_len * step;
                        base = m_addr - (m_addr % blk);
                        m_addr = base + ((m_addr - base + step) % blk);
                    end else m_addr = m_addr + step;
                    ev.v = 1'b1; ev.a = m_addr; ev.i = 10'(m_cnt);
                    m_cnt++;
                    if (m_fixed && m_cnt == m_len) begin ev.e = 1'b1; m_open = 0; end
                end
            end
        end
        if (ev.v || ev.e || ev.t || ev.p) begin
            exp_q.push_back(ev);
            tag_q.push_back(tag);
        end
    endtask

    always @(negedge clk) begin
        ev_t act, ex;
        string tg;
        if (rst_n && !done) begin
            act = {beat_vld, beat_addr, beat_idx, burst_start, burst_end, early_term, early_cnt, proto_err};
            if (act.v || act.e || act.t || act.p) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL unexpected event: actual=%h expected=none", act);
                end else begin
                    ex = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    if (act !== ex) begin
                        failures++;
                        $display("FAIL %s: actual=%h expected=%h", tg, act, ex);
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of all outputs
        checks++;
        if ({beat_vld, beat_addr, beat_idx, burst_start, burst_end, early_term, early_cnt, proto_err} !== '0) begin
            failures++;
            $display("FAIL R1 reset outputs: actual=%h expected=0",
                     {beat_vld, beat_addr, beat_idx, burst_start, burst_end, early_term, early_cnt, proto_err});
        end
        cyc(1, K_SEQ, B_INCR, 3'd2, 32'h40, 1, "R1 R10 orphan after reset");
        // R3 R4: full INCR4 word burst, wrong bus address on one SEQ beat
        cyc(1, K_NSEQ, B_INCR4, 3'd2, 32'h100, 1, "R3 incr4 open");
        cyc(1, K_SEQ, B_INCR4, 3'd2, 32'h104, 1, "R4 incr4 beat1");
        cyc(1, K_SEQ, B_INCR4, 3'd2, 32'hDEAD0000, 1, "R4 incr4 bus addr ignored");
        cyc(1, K_SEQ, B_INCR4, 3'd2, 32'h10C, 1, "R6 incr4 last beat ends");
        cyc(1, K_SEQ, B_INCR4, 3'd2, 32'h110, 1, "R6 extra beat is orphan");
        cyc(1, K_IDLE, B_INCR4, 3'd2, 32'h0, 1, "R7 idle no event");
        // R5: wrapping bursts, several sizes
        cyc(1, K_NSEQ, B_WRAP4, 3'd2, 32'h38, 1, "R5 wrap4 open");
        for (int n = 0; n < 3; n++) cyc(1, K_SEQ, B_WRAP4, 3'd2, 32'h0, 1, "R5 wrap4 word");
        cyc(1, K_NSEQ, B_WRAP8, 3'd1, 32'h1A, 1, "R5 wrap8 open");
        for (int n = 0; n < 7; n++) cyc(1, K_SEQ, B_WRAP8, 3'd1, 32'h0, 1, "R5 wrap8 halfword");
        cyc(1, K_NSEQ, B_WRAP16, 3'd0, 32'h20F, 1, "R5 wrap16 open");
        for (int n = 0; n < 15; n++) cyc(1, K_SEQ, B_WRAP16, 3'd0, 32'h0, 1, "R5 wrap16 byte");
        // R7 R8: undefined-length burst closed by IDLE, no early_term
        cyc(1, K_NSEQ, B_INCR, 3'd0, 32'h200, 1, "R7 incr open");
        cyc(1, K_SEQ, B_INCR, 3'd0, 32'h201, 1, "R4 incr byte step");
        cyc(1, K_SEQ, B_INCR, 3'd0, 32'h202, 1, "R4 incr byte step");
        cyc(1, K_IDLE, B_INCR, 3'd0, 32'h0, 1, "R7 R8 incr close no eterm");
        // R9 R11 R8: INCR8 with BUSY and stalls, then truncated
        cyc(1, K_NSEQ, B_INCR8, 3'd2, 32'h400, 1, "R9 incr8 open");
        cyc(1, K_SEQ, B_INCR8, 3'd2, 32'h404, 1, "R9 incr8 beat1");
        cyc(1, K_BUSY, B_INCR8, 3'd2, 32'h408, 1, "R9 busy");
        cyc(1, K_BUSY, B_INCR8, 3'd2, 32'h408, 1, "R9 busy");
        cyc(1, K_SEQ, B_INCR8, 3'd2, 32'h999, 0, "R11 stalled seq ignored");
        cyc(1, K_IDLE, B_INCR8, 3'd2, 32'h0, 0, "R11 stalled idle ignored");
        cyc(1, K_SEQ, B_INCR8, 3'd2, 32'h408, 1, "R9 resume after busy");
        cyc(1, K_IDLE, B_INCR8, 3'd2, 32'h0, 1, "R8 early term count 3");
        // R7 R8: NONSEQ restart truncates INCR4, then deselect closes
        cyc(1, K_NSEQ, B_INCR4, 3'd2, 32'h500, 1, "R3 incr4 open");
        cyc(1, K_SEQ, B_INCR4, 3'd2, 32'h504, 1, "R4 incr4 beat1");
        cyc(1, K_NSEQ, B_INCR, 3'd1, 32'h600, 1, "R7 R8 restart by nonseq");
        cyc(1, K_SEQ, B_INCR, 3'd1, 32'h602, 1, "R4 halfword step");
        cyc(0, K_SEQ, B_INCR, 3'd1, 32'h604, 1, "R7 deselect closes");
        // R10: IDLE drops context, BUSY then SEQ is orphan
        cyc(1, K_NSEQ, B_INCR, 3'd2, 32'h700, 1, "R3 incr open");
        cyc(1, K_SEQ, B_INCR, 3'd2, 32'h704, 1, "R4 incr beat1");
        cyc(1, K_IDLE, B_INCR, 3'd2, 32'h0, 1, "R7 idle close");
        cyc(1, K_BUSY, B_INCR, 3'd2, 32'h708, 1, "R2 busy while idle");
        cyc(1, K_SEQ, B_INCR, 3'd2, 32'h708, 1, "R10 seq after idle is orphan");
        // R6: single-beat burst; R2: deselected NONSEQ gives no beat
        cyc(1, K_NSEQ, B_SINGLE, 3'd2, 32'h800, 1, "R6 single start and end");
        cyc(0, K_NSEQ, B_INCR4, 3'd2, 32'h900, 1, "R2 deselected nonseq");
        cyc(1, K_SEQ, B_INCR4, 3'd2, 32'h904, 1, "R2 R10 seq after deselected nonseq");
        cyc(1, K_IDLE, B_INCR, 3'd0, 32'h0, 1, "idle");
        cyc(1, K_IDLE, B_INCR, 3'd0, 32'h0, 1, "idle");
        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R2 missing events: actual=%0d pending expected=0 (first %s)", exp_q.size(), tag_q[0]);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule